// File: doc/BRIEF.md
# Deferred Fault Tracker for Early-Issued Loads

A load may be hoisted by the scheduler to a point well ahead of where the program originally placed it, so that its data is ready when it is needed. That early load may fault, for example on an invalid address. The fault must not be taken at that point, because the program might never have reached the load. This unit keeps one deferred-fault token for each general register. A faulting early load sets the token of its destination register. A clean early load, or any ordinary write to that register, clears the token.

A check operation sits where the load originally stood. When the check executes, the unit looks up the token of the named register. If the token is set, the unit raises the exception for one cycle, reports the register, and drops the token. If the token is clear, the unit confirms that the register holds valid data and changes nothing. If control flow never reaches the check, the token is simply overwritten later or left in place, and no exception is ever taken.

Events that meet in the same cycle resolve in a fixed order: the ordinary write first, then the early-load completion, then the check. A check therefore sees the result of a load completion that lands on the same register in the same cycle. Memory, address generation and trap handling sit outside the unit.

Top module: `deferred_fault_tracker`

## Requirements
- R1: After synchronous reset, every register's token is clear and `raise_exc`, `chk_pass` and `exc_reg` are 0.
- R2: An early-load completion with `sld_fault`=1 sets the token of register `sld_reg`.
- R3: An early-load completion with `sld_fault`=0 clears the token of register `sld_reg`.
- R4: An ordinary write (`wr_vld`=1) clears the token of register `wr_reg`.
- R5: A check on a register whose token is set drives `raise_exc`=1, `chk_pass`=0 and `exc_reg`=the checked index in the cycle after the check. When `raise_exc` is 0, `exc_reg` reads 0.
- R6: A check that raises also clears the token, so a repeated check of the same register passes.
- R7: A check on a register whose token is clear drives `chk_pass`=1 and `raise_exc`=0 in the cycle after the check, and leaves all tokens unchanged.
- R8: When a check and an early-load completion name the same register in the same cycle, the completion is applied first: a faulting completion makes the check raise, and a clean completion makes it pass.
- R9: When an ordinary write and an early-load completion name the same register in the same cycle, the completion takes effect, so a faulting completion leaves the token set.
- R10: A set token is held for any number of cycles without a check and produces no exception until a check on that register executes.
- R11: `raise_exc` and `chk_pass` are each high for exactly the single cycle after a check, are never high together, and are both 0 in any cycle that does not follow a check.
- R12: Tokens are independent: an event on one register never changes the token of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sld_vld | input | 1 | Early-load completion this cycle |
| sld_reg | input | 7 | Destination register of the completing load |
| sld_fault | input | 1 | The completing load faulted |
| wr_vld | input | 1 | Ordinary register write this cycle |
| wr_reg | input | 7 | Register written |
| chk_vld | input | 1 | Check operation executes this cycle |
| chk_reg | input | 7 | Register named by the check |
| raise_exc | output | 1 | Deferred exception taken (one cycle) |
| exc_reg | output | 7 | Faulting register while `raise_exc` is high, else 0 |
| chk_pass | output | 1 | Check found valid data (one cycle) |

## Verification
Token updates take effect at the clock edge where the event is sampled. A check's verdict (`raise_exc` or `chk_pass`, with `exc_reg`) appears on the outputs exactly one cycle after the check is presented, with nothing between the check and the output register. The bench drives every input at the falling edge. At the next falling edge it compares the outputs against a behavioural model that applied the previous cycle's events in write, completion, check order. So every clock is checked exactly at the cycle where the verdict is due. Directed sequences cover the same-cycle collisions, long holds without a check and repeated checks, and a random phase over a narrow register range forces frequent collisions.

// File: rtl/dft_pkg.sv
package dft_pkg;

    parameter int DFT_NUM_REGS = 128;
    parameter int DFT_IDX_W    = $clog2(DFT_NUM_REGS);

    // Outcome of a check, registered for one cycle.
    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'd0,
        VERDICT_PASS  = 2'd1,
        VERDICT_RAISE = 2'd2
    } verdict_e;

    // Per-register event view produced by the decoder.
    typedef struct packed {
        logic ld_hit;
        logic ld_fault;
        logic wr_hit;
        logic chk_hit;
    } reg_evt_t;

    // Token value after write then completion, before the check.
    function automatic logic merge_token(input logic stored,
                                         input logic wr_hit,
                                         input logic ld_hit,
                                         input logic ld_fault);
        logic t;
        t = stored;
        if (wr_hit) t = 1'b0;
        if (ld_hit) t = ld_fault;
        return t;
    endfunction

    function automatic verdict_e judge(input logic valid, input logic token);
        if (!valid)     return VERDICT_NONE;
        else if (token) return VERDICT_RAISE;
        else            return VERDICT_PASS;
    endfunction

endpackage

// File: rtl/dft_event_decode.sv
module dft_event_decode
    import dft_pkg::*;
#(
    parameter int NUM_REGS = DFT_NUM_REGS,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             sld_vld,
    input  logic [IDX_W-1:0] sld_reg,
    input  logic             sld_fault,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_reg,
    input  logic             chk_vld,
    input  logic [IDX_W-1:0] chk_reg,
    output reg_evt_t         evt [NUM_REGS]
);

    // One comparator slice per register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        localparam logic [IDX_W-1:0] SELF = IDX_W'(i);
        always_comb begin
            evt[i].ld_hit   = sld_vld && (sld_reg == SELF);
            evt[i].ld_fault = sld_fault;
            evt[i].wr_hit   = wr_vld && (wr_reg == SELF);
            evt[i].chk_hit  = chk_vld && (chk_reg == SELF);
        end
    end

endmodule

// File: rtl/dft_token_bank.sv
module dft_token_bank
    import dft_pkg::*;
#(
    parameter int NUM_REGS = DFT_NUM_REGS
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_evt_t evt [NUM_REGS],
    output logic     token [NUM_REGS]
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_tok
        logic nxt;
        always_comb begin
            nxt = merge_token(token[i], evt[i].wr_hit,
                              evt[i].ld_hit, evt[i].ld_fault);
            // A check consumes the token whatever its value.
            if (evt[i].chk_hit) nxt = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst) token[i] <= 1'b0;
            else     token[i] <= nxt;
        end
    end

endmodule

// File: rtl/dft_check_unit.sv
module dft_check_unit
    import dft_pkg::*;
#(
    parameter int NUM_REGS = DFT_NUM_REGS,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             token [NUM_REGS],
    input  logic             sld_vld,
    input  logic [IDX_W-1:0] sld_reg,
    input  logic             sld_fault,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_reg,
    input  logic             chk_vld,
    input  logic [IDX_W-1:0] chk_reg,
    output logic             raise_exc,
    output logic [IDX_W-1:0] exc_reg,
    output logic             chk_pass
);

    logic     stored;
    logic     eff;
    verdict_e verdict_d;
    verdict_e verdict_q;
    logic [IDX_W-1:0] idx_q;

    assign stored = token[chk_reg];

    // Forward same-cycle write and completion ahead of the lookup.
    assign eff = merge_token(stored,
                             wr_vld  && (wr_reg  == chk_reg),
                             sld_vld && (sld_reg == chk_reg),
                             sld_fault);

    assign verdict_d = judge(chk_vld, eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= VERDICT_NONE;
            idx_q     <= '0;
        end else begin
            verdict_q <= verdict_d;
            idx_q     <= (verdict_d == VERDICT_RAISE) ? chk_reg : '0;
        end
    end

    assign raise_exc = (verdict_q == VERDICT_RAISE);
    assign chk_pass  = (verdict_q == VERDICT_PASS);
    assign exc_reg   = idx_q;

endmodule

// File: rtl/deferred_fault_tracker.sv
module deferred_fault_tracker
    import dft_pkg::*;
#(
    parameter int NUM_REGS = DFT_NUM_REGS,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sld_vld,
    input  logic [IDX_W-1:0] sld_reg,
    input  logic             sld_fault,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_reg,
    input  logic             chk_vld,
    input  logic [IDX_W-1:0] chk_reg,
    output logic             raise_exc,
    output logic [IDX_W-1:0] exc_reg,
    output logic             chk_pass
);

    reg_evt_t evt   [NUM_REGS];
    logic     token [NUM_REGS];

    dft_event_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .sld_vld   (sld_vld),
        .sld_reg   (sld_reg),
        .sld_fault (sld_fault),
        .wr_vld    (wr_vld),
        .wr_reg    (wr_reg),
        .chk_vld   (chk_vld),
        .chk_reg   (chk_reg),
        .evt       (evt)
    );

    dft_token_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .token (token)
    );

    dft_check_unit #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk_unit (
        .clk       (clk),
        .rst       (rst),
        .token     (token),
        .sld_vld   (sld_vld),
        .sld_reg   (sld_reg),
        .sld_fault (sld_fault),
        .wr_vld    (wr_vld),
        .wr_reg    (wr_reg),
        .chk_vld   (chk_vld),
        .chk_reg   (chk_reg),
        .raise_exc (raise_exc),
        .exc_reg   (exc_reg),
        .chk_pass  (chk_pass)
    );

endmodule

// File: rtl/dft_checker.sv
module dft_checker #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             sld_vld,
    input logic [IDX_W-1:0] sld_reg,
    input logic             sld_fault,
    input logic             wr_vld,
    input logic [IDX_W-1:0] wr_reg,
    input logic             chk_vld,
    input logic [IDX_W-1:0] chk_reg,
    input logic             raise_exc,
    input logic [IDX_W-1:0] exc_reg,
    input logic             chk_pass
);

    // R11
    verdict_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(raise_exc && chk_pass));

    // R11
    check_answered_chk: assert property (@(posedge clk) disable iff (rst)
        chk_vld |=> (raise_exc || chk_pass));

    // R11
    no_idle_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_vld |=> (!raise_exc && !chk_pass));

    // R5
    raise_index_chk: assert property (@(posedge clk) disable iff (rst)
        chk_vld |=> (!raise_exc || exc_reg == $past(chk_reg)));

    // R5
    quiet_index_chk: assert property (@(posedge clk) disable iff (rst)
        !raise_exc |-> (exc_reg == '0));

    // R8
    fwd_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_vld && sld_vld && sld_reg == chk_reg && sld_fault) |=> raise_exc);

    // R8
    fwd_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_vld && sld_vld && sld_reg == chk_reg && !sld_fault) |=> chk_pass);

    // R6
    repeat_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_vld && !sld_vld && !wr_vld && $past(chk_vld) && chk_reg == $past(chk_reg))
        |=> chk_pass);

endmodule

bind deferred_fault_tracker dft_checker #(.IDX_W(IDX_W)) u_dft_checker (
    .clk       (clk),
    .rst       (rst),
    .sld_vld   (sld_vld),
    .sld_reg   (sld_reg),
    .sld_fault (sld_fault),
    .wr_vld    (wr_vld),
    .wr_reg    (wr_reg),
    .chk_vld   (chk_vld),
    .chk_reg   (chk_reg),
    .raise_exc (raise_exc),
    .exc_reg   (exc_reg),
    .chk_pass  (chk_pass)
);

// File: tb/deferred_fault_tracker_tb.sv
module deferred_fault_tracker_tb;

    localparam int N  = 128;
    localparam int IW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sld_vld = 1'b0, sld_fault = 1'b0, wr_vld = 1'b0, chk_vld = 1'b0;
    logic [IW-1:0] sld_reg = '0, wr_reg = '0, chk_reg = '0;
    logic raise_exc, chk_pass;
    logic [IW-1:0] exc_reg;

    always #5 clk = ~clk;

    deferred_fault_tracker u_dut (
        .clk(clk), .rst(rst),
        .sld_vld(sld_vld), .sld_reg(sld_reg), .sld_fault(sld_fault),
        .wr_vld(wr_vld), .wr_reg(wr_reg),
        .chk_vld(chk_vld), .chk_reg(chk_reg),
        .raise_exc(raise_exc), .exc_reg(exc_reg), .chk_pass(chk_pass)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit model_tok [N];
    bit exp_raise = 0, exp_pass = 0;
    int exp_reg = 0;
    string exp_tag = "R1";

    // Compare outputs due from the previous cycle's stimulus.
    task automatic compare();
        checks++;
        if (raise_exc !== exp_raise || chk_pass !== exp_pass || int'(exc_reg) != exp_reg) begin
            errors++;
            $display("FAIL %s: raise=%0b pass=%0b reg=%0d expected raise=%0b pass=%0b reg=%0d",
                     exp_tag, raise_exc, chk_pass, exc_reg, exp_raise, exp_pass, exp_reg);
        end
    endtask

    // One clock: check previous verdict, drive new events, update model.
    task automatic step(input bit lv, input int lr, input bit lf,
                        input bit wv, input int wrr,
                        input bit cv, input int cr, input string tag);
        bit t;
        @(negedge clk);
        compare();
        sld_vld = lv; sld_reg = IW'(lr); sld_fault = lf;
        wr_vld = wv;  wr_reg = IW'(wrr);
        chk_vld = cv; chk_reg = IW'(cr);
        if (wv) model_tok[wrr] = 1'b0;
        if (lv) model_tok[lr] = lf;
        exp_raise = 0; exp_pass = 0; exp_reg = 0;
        if (cv) begin
            t = model_tok[cr];
            exp_raise = t;
            exp_pass  = !t;
            exp_reg   = t ? cr : 0;
            model_tok[cr] = 1'b0;
        end
        exp_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) model_tok[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();  // R1 outputs during reset
        rst = 1'b0;
        // R1: fresh tokens all clear
        step(0, 0, 0, 0, 0, 1, 0,   "R1");
        step(0, 0, 0, 0, 0, 1, 127, "R1");
        step(0, 0, 0, 0, 0, 1, 64,  "R1");
        // R2 + R5 + R6
        step(1, 5, 1, 0, 0, 0, 0, "R2");
        idle("R11");
        step(0, 0, 0, 0, 0, 1, 5, "R5");
        step(0, 0, 0, 0, 0, 1, 5, "R6");
        idle("R11");
        // R3
        step(1, 9, 1, 0, 0, 0, 0, "R2");
        step(1, 9, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 1, 9, "R3");
        // R4
        step(1, 10, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 1, 10, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 1, 10, "R4");
        // R7: clean check leaves neighbour token intact
        step(1, 20, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 21, "R7");
        step(0, 0, 0, 0, 0, 1, 21, "R7");
        step(0, 0, 0, 0, 0, 1, 20, "R7");
        // R8: same-cycle completion and check
        step(1, 30, 1, 0, 0, 1, 30, "R8");
        step(1, 31, 1, 0, 0, 0, 0, "R2");
        step(1, 31, 0, 0, 0, 1, 31, "R8");
        // R9: write and faulting completion collide
        step(1, 40, 1, 1, 40, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 1, 40, "R9");
        // R10: long hold, no check means no exception
        step(1, 50, 1, 0, 0, 0, 0, "R2");
        for (int k = 0; k < 200; k++) idle("R10");
        step(0, 0, 0, 0, 0, 1, 50, "R10");
        // R12: neighbours untouched
        step(1, 60, 1, 0, 0, 0, 0, "R2");
        step(1, 61, 0, 1, 59, 1, 62, "R12");
        step(0, 0, 0, 0, 0, 1, 60, "R12");
        step(0, 0, 0, 0, 0, 1, 127, "R5");
        step(1, 127, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 127, "R5");
        // Random phase over a narrow range to force collisions
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 2) == 0, $urandom % 6, ($urandom % 3) != 0,
                 ($urandom % 4) == 0, $urandom % 6,
                 ($urandom % 2) == 0, $urandom % 6, "R12");
        end
        idle("R11");
        idle("R11");
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule